// File: doc/BRIEF.md
# ADC Burst and Tracking Sequencer

This block controls when a successive-approximation converter is powered, when its sampling capacitor tracks the input, and when the bit-cycling phase may start. A single-cycle convert-start pulse begins a conversion. If the converter is held in low power between conversions, the sequencer first waits a programmable warm-up time. It then tracks the input for the selected tracking scheme and raises a convert request. The request stays high until the converter reports that it has finished.

Three tracking schemes are available. In post-start tracking, sampling begins only after the start pulse. In idle tracking, the input is sampled continuously while the block is idle and powered, so a start goes straight to conversion. Dual tracking combines the two. The post-start interval is counted in SAR clock enables and is followed by two system clocks. The warm-up wait is counted in units of 200 ns. A parameter gives the number of system clocks in one unit.

Top module: `adc_burst_seq`

## Requirements
- R1: After reset, busy_o, conv_req_o and track_o are low and the block is idle.
- R2: With burst_en_i low, power_on_o equals enable_i while idle. A start pulse with both burst_en_i and enable_i low is ignored: busy_o stays low.
- R3: With burst_en_i and enable_i both high, power stays on through a conversion and tracking starts on the cycle after the start, with no warm-up.
- R4: With burst_en_i high and enable_i low, power_on_o is low while idle. After a start it is high for exactly (pwrup_cfg_i+1)*CLKS_PER_UNIT cycles before tracking begins, and it falls again when the conversion completes.
- R5: Mode code 01 (post-start tracking) and reserved code 00 keep track_o low while idle and raise it for the post-start interval after a start.
- R6: The post-start interval lasts 2, 4, 8 or 16 cycles with sar_ce_i high (post_cfg_i = 00, 01, 10, 11), followed by 2 system clocks. Cycles with sar_ce_i low do not advance the interval.
- R7: Mode code 10 (idle tracking) holds track_o high while idle and powered. A start with no warm-up raises conv_req_o on the next cycle, with track_o low.
- R8: Mode code 11 (dual) holds track_o high while idle and powered, and also for the post-start interval after a start.
- R9: conv_req_o stays high, with track_o low, until conv_done_i is seen. The cycle after that, busy_o and conv_req_o are low.
- R10: A start pulse while busy_o is high has no effect: the interval is not restarted and no extra conversion follows.
- R11: After a warm-up, every mode (idle tracking included) tracks for the post-start interval before the request, because no idle sampling took place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Single-cycle convert-start pulse |
| enable_i | input | 1 | Converter enable |
| burst_en_i | input | 1 | Low-power-between-conversions enable |
| pwrup_cfg_i | input | 4 | Warm-up length in 200 ns units, minus one |
| track_mode_i | input | 2 | Tracking scheme: 00/01 post, 10 idle, 11 dual |
| post_cfg_i | input | 2 | Post-start interval select |
| sar_ce_i | input | 1 | SAR clock enable |
| conv_done_i | input | 1 | Conversion finished |
| power_on_o | output | 1 | Converter power request |
| track_o | output | 1 | Track (sample) control |
| conv_req_o | output | 1 | Conversion phase request |
| busy_o | output | 1 | A conversion sequence is in progress |

## Verification
The hardest case to reach is a post-start interval frozen midway because sar_ce_i is held low, combined with a start pulse that arrives while that interval is running. The stimulus holds the SAR enable low after a start and confirms that tracking persists with no request. It then releases the enable and counts the remaining tracking cycles exactly. A separate scenario injects a second start a few cycles into a 16-enable interval and requires the full 18-cycle track window and a single completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_POST = 2'd2,
    ST_CONV = 2'd3
  } seq_state_e;

  localparam int unsigned CFG_W       = 4;
  localparam int unsigned MODE_W      = 2;
  localparam int unsigned POST_CODE_W = 2;
  localparam int unsigned POST_CNT_W  = 5;
  localparam int unsigned FIN_CLKS    = 2;

  localparam logic [MODE_W-1:0] MODE_RSVD = 2'b00;
  localparam logic [MODE_W-1:0] MODE_POST = 2'b01;
  localparam logic [MODE_W-1:0] MODE_PRE  = 2'b10;
  localparam logic [MODE_W-1:0] MODE_DUAL = 2'b11;

  function automatic logic idle_tracks(input logic [MODE_W-1:0] mode);
    return (mode == MODE_PRE) || (mode == MODE_DUAL);
  endfunction

endpackage

// File: rtl/adc_unit_timer.sv
module adc_unit_timer #(
  parameter int unsigned CLKS_PER_UNIT = 40,
  parameter int unsigned UNITS_W       = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [UNITS_W-1:0] units_i,
  output logic               done_o
);

  logic               unit_tick;
  logic [UNITS_W-1:0] unit_q, unit_d;

  generate
    if (CLKS_PER_UNIT > 1) begin : g_prescale
      localparam int unsigned PRE_W = $clog2(CLKS_PER_UNIT);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_UNIT - 1);
      logic [PRE_W-1:0] pre_q, pre_d;

      assign unit_tick = (pre_q == PRE_LAST);

      always_comb begin
        pre_d = '0;
        if (run_i && !unit_tick) pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
      end
    end else begin : g_direct
      assign unit_tick = 1'b1;
    end
  endgenerate

  always_comb begin
    unit_d = '0;
    if (run_i) unit_d = unit_tick ? unit_q + 1'b1 : unit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unit_q <= '0;
    else         unit_q <= unit_d;
  end

  assign done_o = run_i && unit_tick && (unit_q == units_i);

endmodule

// File: rtl/adc_post_timer.sv
module adc_post_timer
  import adc_seq_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic                   sar_ce_i,
  input  logic [POST_CODE_W-1:0] code_i,
  output logic                   done_o
);

  localparam logic [POST_CNT_W-1:0] FIN_LAST = POST_CNT_W'(FIN_CLKS - 1);

  logic [POST_CNT_W-1:0] cnt_q, cnt_d;
  logic                  fin_q, fin_d;
  logic [POST_CNT_W-1:0] sar_last;

  assign sar_last = (POST_CNT_W'(2) << code_i) - 1'b1;

  always_comb begin
    cnt_d = '0;
    fin_d = 1'b0;
    if (run_i) begin
      cnt_d = cnt_q;
      fin_d = fin_q;
      if (fin_q) begin
        cnt_d = cnt_q + 1'b1;
      end else if (sar_ce_i) begin
        if (cnt_q == sar_last) begin
          cnt_d = '0;
          fin_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fin_q <= fin_d;
    end
  end

  assign done_o = run_i && fin_q && (cnt_q == FIN_LAST);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              enable_i,
  input  logic              burst_en_i,
  input  logic [MODE_W-1:0] track_mode_i,
  input  logic              wake_done_i,
  input  logic              post_done_i,
  input  logic              conv_done_i,
  output logic              wake_run_o,
  output logic              post_run_o,
  output logic              power_on_o,
  output logic              track_o,
  output logic              conv_req_o,
  output logic              busy_o
);

  seq_state_e state_q, state_d;
  logic       start_ok;
  logic       need_wake;

  assign start_ok  = conv_start_i && (enable_i || burst_en_i);
  assign need_wake = burst_en_i && !enable_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          if (need_wake)                    state_d = ST_WAKE;
          else if (track_mode_i == MODE_PRE) state_d = ST_CONV;
          else                              state_d = ST_POST;
        end
      end
      ST_WAKE: if (wake_done_i) state_d = ST_POST;
      ST_POST: if (post_done_i) state_d = ST_CONV;
      ST_CONV: if (conv_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign wake_run_o = (state_q == ST_WAKE);
  assign post_run_o = (state_q == ST_POST);
  assign busy_o     = (state_q != ST_IDLE);
  assign conv_req_o = (state_q == ST_CONV);
  assign power_on_o = enable_i || busy_o;
  assign track_o    = (state_q == ST_POST) ||
                      ((state_q == ST_IDLE) && enable_i && idle_tracks(track_mode_i));

endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLKS_PER_UNIT = 40
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   conv_start_i,
  input  logic                   enable_i,
  input  logic                   burst_en_i,
  input  logic [CFG_W-1:0]       pwrup_cfg_i,
  input  logic [MODE_W-1:0]      track_mode_i,
  input  logic [POST_CODE_W-1:0] post_cfg_i,
  input  logic                   sar_ce_i,
  input  logic                   conv_done_i,
  output logic                   power_on_o,
  output logic                   track_o,
  output logic                   conv_req_o,
  output logic                   busy_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       wake_run, wake_done;
  logic       post_run, post_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  adc_seq_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .conv_start_i (conv_start_i),
    .enable_i     (enable_i),
    .burst_en_i   (burst_en_i),
    .track_mode_i (track_mode_i),
    .wake_done_i  (wake_done),
    .post_done_i  (post_done),
    .conv_done_i  (conv_done_i),
    .wake_run_o   (wake_run),
    .post_run_o   (post_run),
    .power_on_o   (power_on_o),
    .track_o      (track_o),
    .conv_req_o   (conv_req_o),
    .busy_o       (busy_o)
  );

  adc_unit_timer #(
    .CLKS_PER_UNIT (CLKS_PER_UNIT),
    .UNITS_W       (CFG_W)
  ) u_wake (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .run_i   (wake_run),
    .units_i (pwrup_cfg_i),
    .done_o  (wake_done)
  );

  adc_post_timer u_post (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .run_i    (post_run),
    .sar_ce_i (sar_ce_i),
    .code_i   (post_cfg_i),
    .done_o   (post_done)
  );

endmodule

// File: rtl/adc_burst_seq_chk.sv
module adc_burst_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       conv_start_i,
  input logic       enable_i,
  input logic       burst_en_i,
  input logic [1:0] track_mode_i,
  input logic       conv_done_i,
  input logic       power_on_o,
  input logic       track_o,
  input logic       conv_req_o,
  input logic       busy_o
);

  AST_REQ_NO_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> !track_o); // R9

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !conv_done_i) |=> conv_req_o); // R9

  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && conv_done_i) |=> !busy_o); // R9

  AST_BUSY_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> power_on_o); // R4

  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_en_i && !enable_i && !busy_o) |-> !power_on_o); // R2

  AST_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(conv_start_i)); // R10

  AST_PRE_IDLE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && enable_i && track_mode_i == 2'b10) |-> track_o); // R7

endmodule

bind adc_burst_seq adc_burst_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_start_i (conv_start_i),
  .enable_i     (enable_i),
  .burst_en_i   (burst_en_i),
  .track_mode_i (track_mode_i),
  .conv_done_i  (conv_done_i),
  .power_on_o   (power_on_o),
  .track_o      (track_o),
  .conv_req_o   (conv_req_o),
  .busy_o       (busy_o)
);

// File: tb/sim_adc_burst_seq.sv
`timescale 1ns/1ps
module sim_adc_burst_seq;

  localparam int UNIT = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       conv_start, enable, burst_en, sar_ce, conv_done;
  logic [3:0] pwrup_cfg;
  logic [1:0] track_mode, post_cfg;
  logic       power_on, track, conv_req, busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  adc_burst_seq #(.CLKS_PER_UNIT(UNIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .conv_start_i(conv_start), .enable_i(enable),
    .burst_en_i(burst_en), .pwrup_cfg_i(pwrup_cfg), .track_mode_i(track_mode),
    .post_cfg_i(post_cfg), .sar_ce_i(sar_ce), .conv_done_i(conv_done),
    .power_on_o(power_on), .track_o(track), .conv_req_o(conv_req), .busy_o(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_sim();
    end
  end

  // One conversion: start, count warm-up and tracking cycles, then complete.
  task automatic run_conv(input string req, input int exp_wake, input int exp_trk,
                          input int inject_at);
    int wake_n = 0;
    int trk_n  = 0;
    int idx    = 0;
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    while (!conv_req && idx < 5000) begin
      if (busy && power_on && !track) wake_n++;
      if (busy && track) trk_n++;
      conv_start = (idx == inject_at);
      idx++;
      @(negedge clk);
    end
    conv_start = 1'b0;
    check({req, " warm-up cycles"}, wake_n, exp_wake);
    check({req, " track cycles"}, trk_n, exp_trk);
    repeat (3) @(negedge clk);
    check("R9 request held", {conv_req, track}, 2'b10);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check("R9 idle after done", {busy, conv_req}, 2'b00);
    @(negedge clk);
    check("R10 no extra conversion", busy, 0);
  endtask

  task automatic t_reset();
    check("R1 reset outputs", {busy, conv_req, track}, 3'b000);
  endtask

  task automatic t_power_follow();
    burst_en = 0; enable = 0; track_mode = 2'b01;
    @(negedge clk);
    check("R2 power off", power_on, 0);
    conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 start ignored", busy, 0);
    enable = 1; @(negedge clk);
    check("R2 power follows enable", power_on, 1);
  endtask

  task automatic t_post_modes();
    burst_en = 0; enable = 1; sar_ce = 1;
    for (int c = 0; c < 4; c++) begin
      track_mode = 2'b01; post_cfg = c[1:0];
      @(negedge clk);
      check("R5 idle track low", track, 0);
      run_conv("R6 post code", 0, (2 << c) + 2, -1);
    end
    track_mode = 2'b00; post_cfg = 2'b01;
    @(negedge clk);
    check("R5 reserved idle track low", track, 0);
    run_conv("R5 reserved mode", 0, 6, -1);
  endtask

  task automatic t_pre();
    burst_en = 0; enable = 1; track_mode = 2'b10; post_cfg = 2'b11;
    @(negedge clk);
    check("R7 idle tracking", track, 1);
    run_conv("R7 direct convert", 0, 0, -1);
    check("R7 tracking resumes", track, 1);
  endtask

  task automatic t_dual();
    burst_en = 0; enable = 1; track_mode = 2'b11; post_cfg = 2'b10;
    @(negedge clk);
    check("R8 idle tracking", track, 1);
    run_conv("R8 dual", 0, 10, -1);
  endtask

  task automatic t_burst_on();
    burst_en = 1; enable = 1; track_mode = 2'b01; post_cfg = 2'b00;
    @(negedge clk);
    check("R3 powered idle", power_on, 1);
    run_conv("R3 no warm-up", 0, 4, -1);
    check("R3 still powered", power_on, 1);
  endtask

  task automatic t_burst_wake();
    burst_en = 1; enable = 0; track_mode = 2'b01; post_cfg = 2'b00;
    pwrup_cfg = 4'd0;
    @(negedge clk);
    check("R4 low power idle", power_on, 0);
    run_conv("R4 warm-up P0", UNIT, 4, -1);
    check("R4 power drops", power_on, 0);
    pwrup_cfg = 4'd3;
    run_conv("R4 warm-up P3", 4 * UNIT, 4, -1);
    track_mode = 2'b10; pwrup_cfg = 4'd1; post_cfg = 2'b01;
    @(negedge clk);
    check("R11 no idle tracking unpowered", track, 0);
    run_conv("R11 tracks after warm-up", 2 * UNIT, 6, -1);
  endtask

  task automatic t_stall();
    int trk_n = 0;
    burst_en = 0; enable = 1; track_mode = 2'b01; post_cfg = 2'b00; sar_ce = 0;
    conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 stalled tracking", {track, conv_req}, 2'b10);
    sar_ce = 1;
    @(negedge clk);
    while (track && trk_n < 100) begin
      trk_n++;
      @(negedge clk);
    end
    check("R6 remaining after stall", trk_n, 3);
    check("R6 request after stall", conv_req, 1);
    conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
    check("R9 idle after stall", busy, 0);
  endtask

  task automatic t_ignore();
    burst_en = 0; enable = 1; track_mode = 2'b01; post_cfg = 2'b11; sar_ce = 1;
    @(negedge clk);
    run_conv("R10 start while busy", 0, 18, 5);
  endtask

  initial begin
    rst_n = 0; conv_start = 0; enable = 0; burst_en = 0; sar_ce = 1;
    conv_done = 0; pwrup_cfg = 0; track_mode = 2'b01; post_cfg = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_power_follow();
    t_post_modes();
    t_pre();
    t_dual();
    t_burst_on();
    t_burst_wake();
    t_stall();
    t_ignore();
    finish_sim();
  end

endmodule